// File: doc/BRIEF.md
# Powered-Device Discovery Controller

This block sits beside one copper port and decides whether the station at the far end of the cable is a device that expects the port to supply power. It does not see the analog line. It works from single-cycle event strobes that the receive path raises: normal link pulses, MLT3 data, fast link pulse bursts (each with the partner's next-page-ability flag), and the match or mismatch result of a next-page exchange. It also watches link status, the auto-negotiation enable and restart controls, and the expiry of the link-fail-inhibit timer.

Management software sets a sticky enable bit and then polls one status register. While discovery runs, the block asks the auto-negotiation logic to advertise next-page ability. When a partner answers with next-page ability, the block asks for the discovery next-page sequence. A matching exchange with no sign of an ordinary partner raises the power result. Any evidence of an ordinary Ethernet partner raises a sticky indication, and a timer expiry raises a timeout indication and restarts the search.

Top module: `pd_detect_ctl`

## Requirements
- R1: The enable bit (register bit 0) is 0 after reset and is written from write-data bit 0. It changes only on a register write, so no discovery outcome clears it.
- R2: If the enable bit is set while `link_up` is 1, the block stays passive (`adv_np` low) until `link_up` falls. One clock after that, `adv_np` goes high.
- R3: `adv_np` is high only while discovery runs, which needs both the enable bit and `an_enable` at 1. It is low one clock after either of them is 0. After the enable bit is written to 1 with link down, `adv_np` rises two clocks after the write.
- R4: A burst strobe with `flp_np_able` = 1 during the listening phase raises `np_send` one clock later. `np_send` stays high until the exchange resolves.
- R5: The standard-partner bit (register bit 2) is set one clock after any of these: `nlp_seen`, `mlt3_seen`, `flp_rx` with `flp_np_able` = 0, or `np_mismatch` during the next-page exchange.
- R6: The standard-partner bit is cleared by a register read. It is also cleared when the enable bit is 0, when `link_up` is 1, when `an_restart` is 1, or when `an_enable` is 0.
- R7: The power result (register bit 1, also on `pwr_req`) is 0 after reset. It is set one clock after `np_match` during the next-page exchange. Register writes never change bits 1, 2 or 3.
- R8: The power result is cleared one clock after `an_restart` = 1 or `an_enable` = 0. It stays 0 when `link_up` interrupts discovery, and in that case `np_send` drops.
- R9: The timeout bit (register bit 3) is set one clock after `lfi_expired` while discovery runs with link down. The search then returns to listening (`np_send` low), and it can detect partners again.
- R10: The timeout bit is cleared under the same conditions as the standard-partner bit, including by a register read.
- R11: When a clearing read and a set event for the standard-partner or timeout bit happen in the same clock, the bit ends up set.
- R12: `mgmt_rdata` is valid in the same clock as `mgmt_rd` and shows the bit values from before that read's clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_restart | input | 1 | Auto-negotiation restart strobe |
| link_up | input | 1 | Link established |
| nlp_seen | input | 1 | Normal link pulse strobe |
| mlt3_seen | input | 1 | MLT3 data strobe |
| flp_rx | input | 1 | Fast link pulse burst received strobe |
| flp_np_able | input | 1 | Partner next-page-ability flag of the current burst |
| np_match | input | 1 | Partner next page matched the discovery page |
| np_mismatch | input | 1 | Partner next page did not match |
| lfi_expired | input | 1 | Link-fail-inhibit timer expiry strobe |
| mgmt_wr | input | 1 | Register write strobe |
| mgmt_rd | input | 1 | Register read strobe (clears read-to-clear bits) |
| mgmt_wdata | input | DATA_W | Register write data |
| mgmt_rdata | output | DATA_W | Register read data |
| adv_np | output | 1 | Request to advertise next-page ability in the base page |
| np_send | output | 1 | Request to transmit the discovery next-page sequence |
| pwr_req | output | 1 | Power result |

## Verification
On every cycle, the assertions check the following: the enable bit stays put without a write, `adv_np` stays low while link is up in the passive states or once discovery is disabled, `np_send` never rises without `adv_np`, and the status bits fall after link-up, restart or disable. The bench scenarios cover what needs a history to check: each kind of standard-partner evidence, the complete next-page exchange that ends in the power result, and restart after a timer expiry. The bench also shows that a read returns the values from before its clear and that a set wins over a clearing read in the same cycle.

// File: rtl/pd_detect_pkg.sv
package pd_detect_pkg;

   typedef enum logic [2:0] {
      PD_IDLE      = 3'd0,
      PD_WAIT_DOWN = 3'd1,
      PD_LISTEN    = 3'd2,
      PD_NP_TX     = 3'd3,
      PD_FOUND     = 3'd4,
      PD_STANDARD  = 3'd5
   } pd_state_e;

   typedef struct packed {
      logic std_set;
      logic tmo_set;
      logic pwr_set;
      logic pwr_clr;
   } pd_evt_t;

endpackage

// File: rtl/pd_detect_evid.sv
module pd_detect_evid
   import pd_detect_pkg::*;
(
   input  logic      nlp_seen,
   input  logic      mlt3_seen,
   input  logic      flp_rx,
   input  logic      flp_np_able,
   input  logic      np_mismatch,
   input  pd_state_e state,
   output logic      std_evidence,
   output logic      np_request
);

   // Anything that marks an ordinary partner, including a refused page.
   always_comb begin
      std_evidence = nlp_seen | mlt3_seen | (flp_rx & ~flp_np_able)
                   | ((state == PD_NP_TX) & np_mismatch);
      np_request   = flp_rx & flp_np_able;
   end

endmodule

// File: rtl/pd_detect_fsm.sv
module pd_detect_fsm
   import pd_detect_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en,
   input  logic      an_enable,
   input  logic      an_restart,
   input  logic      link_up,
   input  logic      lfi_expired,
   input  logic      np_match,
   input  logic      std_evidence,
   input  logic      np_request,
   output pd_state_e state,
   output pd_evt_t   evt,
   output logic      adv_np,
   output logic      np_send
);

   pd_state_e nxt;
   logic      abort;
   logic      searching;

   always_comb begin
      abort     = ~en | ~an_enable | an_restart;
      searching = (state == PD_LISTEN) | (state == PD_NP_TX);
      nxt       = state;
      evt       = '0;
      evt.pwr_clr = an_restart | ~an_enable | (link_up & searching);
      unique case (state)
         PD_IDLE: begin
            if (!abort) nxt = link_up ? PD_WAIT_DOWN : PD_LISTEN;
         end
         PD_WAIT_DOWN: begin
            if (abort)         nxt = PD_IDLE;
            else if (!link_up) nxt = PD_LISTEN;
         end
         PD_LISTEN, PD_NP_TX, PD_STANDARD: begin
            if (abort)              nxt = PD_IDLE;
            else if (link_up)       nxt = PD_WAIT_DOWN;
            else if (lfi_expired) begin
               nxt         = PD_LISTEN;
               evt.tmo_set = 1'b1;
            end else if (std_evidence) begin
               nxt         = PD_STANDARD;
               evt.std_set = 1'b1;
            end else if (state == PD_LISTEN && np_request) begin
               nxt = PD_NP_TX;
            end else if (state == PD_NP_TX && np_match) begin
               nxt         = PD_FOUND;
               evt.pwr_set = 1'b1;
            end
         end
         PD_FOUND: begin
            if (abort) nxt = PD_IDLE;
         end
         default: nxt = PD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PD_IDLE;
      else        state <= nxt;
   end

   always_comb begin
      adv_np  = (state == PD_LISTEN) | (state == PD_NP_TX)
              | (state == PD_STANDARD) | (state == PD_FOUND);
      np_send = (state == PD_NP_TX);
   end

endmodule

// File: rtl/pd_detect_csr.sv
module pd_detect_csr
   import pd_detect_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int EN_BIT  = 0,
   parameter int PWR_BIT = 1,
   parameter int STD_BIT = 2,
   parameter int TMO_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mgmt_wr,
   input  logic              mgmt_rd,
   input  logic [DATA_W-1:0] mgmt_wdata,
   input  logic              an_enable,
   input  logic              an_restart,
   input  logic              link_up,
   input  pd_evt_t           evt,
   output logic              en_q,
   output logic              pwr_q,
   output logic              std_q,
   output logic              tmo_q,
   output logic [DATA_W-1:0] mgmt_rdata
);

   logic clr_common;
   logic unused_wdata;

   assign clr_common   = ~en_q | link_up | an_restart | ~an_enable;
   assign unused_wdata = ^mgmt_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         pwr_q <= 1'b0;
         std_q <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         if (mgmt_wr) en_q <= mgmt_wdata[EN_BIT];

         if (evt.pwr_clr)      pwr_q <= 1'b0;
         else if (evt.pwr_set) pwr_q <= 1'b1;

         // A set event outranks every clear, the clearing read included.
         if (evt.std_set)                  std_q <= 1'b1;
         else if (clr_common || mgmt_rd)   std_q <= 1'b0;

         if (evt.tmo_set)                  tmo_q <= 1'b1;
         else if (clr_common || mgmt_rd)   tmo_q <= 1'b0;
      end
   end

   // Read data comes from the registers, so it shows the values before this read clears them.
   for (genvar b = 0; b < DATA_W; b++) begin : g_rd
      if (b == EN_BIT)       begin : g_en  assign mgmt_rdata[b] = en_q;  end
      else if (b == PWR_BIT) begin : g_pwr assign mgmt_rdata[b] = pwr_q; end
      else if (b == STD_BIT) begin : g_std assign mgmt_rdata[b] = std_q; end
      else if (b == TMO_BIT) begin : g_tmo assign mgmt_rdata[b] = tmo_q; end
      else                   begin : g_zero assign mgmt_rdata[b] = 1'b0; end
   end

endmodule

// File: rtl/pd_detect_ctl.sv
module pd_detect_ctl
   import pd_detect_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int EN_BIT  = 0,
   parameter int PWR_BIT = 1,
   parameter int STD_BIT = 2,
   parameter int TMO_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              an_enable,
   input  logic              an_restart,
   input  logic              link_up,
   input  logic              nlp_seen,
   input  logic              mlt3_seen,
   input  logic              flp_rx,
   input  logic              flp_np_able,
   input  logic              np_match,
   input  logic              np_mismatch,
   input  logic              lfi_expired,
   input  logic              mgmt_wr,
   input  logic              mgmt_rd,
   input  logic [DATA_W-1:0] mgmt_wdata,
   output logic [DATA_W-1:0] mgmt_rdata,
   output logic              adv_np,
   output logic              np_send,
   output logic              pwr_req
);

   localparam int MAX_BIT = (EN_BIT > PWR_BIT ? EN_BIT : PWR_BIT) > (STD_BIT > TMO_BIT ? STD_BIT : TMO_BIT)
                          ? (EN_BIT > PWR_BIT ? EN_BIT : PWR_BIT) : (STD_BIT > TMO_BIT ? STD_BIT : TMO_BIT);

   if (MAX_BIT >= DATA_W) begin : g_chk_width
      $error("pd_detect_ctl: field position beyond DATA_W");
   end
   if (EN_BIT == PWR_BIT || EN_BIT == STD_BIT || EN_BIT == TMO_BIT ||
       PWR_BIT == STD_BIT || PWR_BIT == TMO_BIT || STD_BIT == TMO_BIT) begin : g_chk_overlap
      $error("pd_detect_ctl: register fields overlap");
   end

   pd_state_e state_q;
   pd_evt_t   evt;
   logic      std_evidence;
   logic      np_request;
   logic      en_q;
   logic      pwr_q;
   logic      std_q;
   logic      tmo_q;

   pd_detect_evid u_evid (
      .nlp_seen     (nlp_seen),
      .mlt3_seen    (mlt3_seen),
      .flp_rx       (flp_rx),
      .flp_np_able  (flp_np_able),
      .np_mismatch  (np_mismatch),
      .state        (state_q),
      .std_evidence (std_evidence),
      .np_request   (np_request)
   );

   pd_detect_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en_q),
      .an_enable    (an_enable),
      .an_restart   (an_restart),
      .link_up      (link_up),
      .lfi_expired  (lfi_expired),
      .np_match     (np_match),
      .std_evidence (std_evidence),
      .np_request   (np_request),
      .state        (state_q),
      .evt          (evt),
      .adv_np       (adv_np),
      .np_send      (np_send)
   );

   pd_detect_csr #(
      .DATA_W  (DATA_W),
      .EN_BIT  (EN_BIT),
      .PWR_BIT (PWR_BIT),
      .STD_BIT (STD_BIT),
      .TMO_BIT (TMO_BIT)
   ) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .mgmt_wr    (mgmt_wr),
      .mgmt_rd    (mgmt_rd),
      .mgmt_wdata (mgmt_wdata),
      .an_enable  (an_enable),
      .an_restart (an_restart),
      .link_up    (link_up),
      .evt        (evt),
      .en_q       (en_q),
      .pwr_q      (pwr_q),
      .std_q      (std_q),
      .tmo_q      (tmo_q),
      .mgmt_rdata (mgmt_rdata)
   );

   assign pwr_req = pwr_q;

endmodule

// File: rtl/pd_detect_chk.sv
module pd_detect_chk
   import pd_detect_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      mgmt_wr,
   input logic      an_enable,
   input logic      an_restart,
   input logic      link_up,
   input logic      adv_np,
   input logic      np_send,
   input logic      en_q,
   input logic      pwr_q,
   input logic      std_q,
   input logic      tmo_q,
   input pd_state_e state_q
);

   a_r1_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !mgmt_wr |=> $stable(en_q));

   a_r2_passive_while_link: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == PD_IDLE || state_q == PD_WAIT_DOWN) && link_up) |=> !adv_np);

   a_r3_adv_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q || !an_enable) |=> !adv_np);

   a_r4_send_within_adv: assert property (@(posedge clk) disable iff (!rst_n)
      np_send |-> adv_np);

   a_r6_std_clear_on_link: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |=> !std_q);

   a_r8_pwr_clear_on_an: assert property (@(posedge clk) disable iff (!rst_n)
      (an_restart || !an_enable) |=> !pwr_q);

   a_r10_tmo_clear_on_link: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |=> !tmo_q);

endmodule

bind pd_detect_ctl pd_detect_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mgmt_wr    (mgmt_wr),
   .an_enable  (an_enable),
   .an_restart (an_restart),
   .link_up    (link_up),
   .adv_np     (adv_np),
   .np_send    (np_send),
   .en_q       (en_q),
   .pwr_q      (pwr_q),
   .std_q      (std_q),
   .tmo_q      (tmo_q),
   .state_q    (state_q)
);

// File: tb/pd_detect_ctl_tb.sv
module pd_detect_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        an_enable = 1'b1;
   logic        an_restart = 1'b0;
   logic        link_up = 1'b0;
   logic        nlp_seen = 1'b0;
   logic        mlt3_seen = 1'b0;
   logic        flp_rx = 1'b0;
   logic        flp_np_able = 1'b0;
   logic        np_match = 1'b0;
   logic        np_mismatch = 1'b0;
   logic        lfi_expired = 1'b0;
   logic        mgmt_wr = 1'b0;
   logic        mgmt_rd = 1'b0;
   logic [15:0] mgmt_wdata = '0;
   logic [15:0] mgmt_rdata;
   logic        adv_np;
   logic        np_send;
   logic        pwr_req;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pd_detect_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_restart(an_restart),
      .link_up(link_up), .nlp_seen(nlp_seen), .mlt3_seen(mlt3_seen), .flp_rx(flp_rx),
      .flp_np_able(flp_np_able), .np_match(np_match), .np_mismatch(np_mismatch),
      .lfi_expired(lfi_expired), .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd),
      .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .adv_np(adv_np),
      .np_send(np_send), .pwr_req(pwr_req)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // Event codes: 0 nlp, 1 mlt3, 2 burst without np, 3 burst with np,
   // 4 np match, 5 np mismatch, 6 timer expiry, 7 an restart
   task automatic set_ev(input int k);
      case (k)
         0: nlp_seen = 1'b1;
         1: mlt3_seen = 1'b1;
         2: begin flp_rx = 1'b1; flp_np_able = 1'b0; end
         3: begin flp_rx = 1'b1; flp_np_able = 1'b1; end
         4: np_match = 1'b1;
         5: np_mismatch = 1'b1;
         6: lfi_expired = 1'b1;
         default: an_restart = 1'b1;
      endcase
   endtask

   task automatic clr_ev();
      nlp_seen = 0; mlt3_seen = 0; flp_rx = 0; flp_np_able = 0;
      np_match = 0; np_mismatch = 0; lfi_expired = 0; an_restart = 0;
   endtask

   task automatic pulse(input int k);
      set_ev(k);
      step();
      clr_ev();
   endtask

   task automatic reg_read(output logic [15:0] v);
      mgmt_rd = 1'b1;
      #1 v = mgmt_rdata;
      step();
      mgmt_rd = 1'b0;
   endtask

   task automatic reg_write(input logic [15:0] v);
      mgmt_wr = 1'b1;
      mgmt_wdata = v;
      step();
      mgmt_wr = 1'b0;
   endtask

   task automatic to_listen();
      pulse(7);
      step();
   endtask

   task automatic t_reset();
      logic [15:0] v;
      reg_read(v);
      chk("R1 reset register", v, 16'h0000);
      chk("R3 adv_np at reset", {15'd0, adv_np}, 16'd0);
      chk("R7 pwr_req at reset", {15'd0, pwr_req}, 16'd0);
   endtask

   task automatic t_enable();
      logic [15:0] v;
      reg_write(16'h0001);
      chk("R3 adv_np one clock after write", {15'd0, adv_np}, 16'd0);
      step();
      chk("R3 adv_np two clocks after write", {15'd0, adv_np}, 16'd1);
      reg_read(v);
      chk("R1 enable reads back", v, 16'h0001);
   endtask

   task automatic t_found();
      logic [15:0] v;
      pulse(3);
      chk("R4 np_send after np burst", {15'd0, np_send}, 16'd1);
      pulse(4);
      chk("R4 np_send drops on match", {15'd0, np_send}, 16'd0);
      chk("R7 pwr_req after match", {15'd0, pwr_req}, 16'd1);
      reg_write(16'h0001);
      reg_read(v);
      chk("R7 power bit survives write", v, 16'h0003);
      pulse(7);
      chk("R8 power cleared by restart", {15'd0, pwr_req}, 16'd0);
      step();
      chk("R8 listening again", {15'd0, adv_np}, 16'd1);
      reg_read(v);
      chk("R8 register after restart", v, 16'h0001);
   endtask

   task automatic t_evidence(input int k);
      logic [15:0] v;
      pulse(k);
      reg_read(v);
      chk($sformatf("R5 standard bit, event %0d", k), v, 16'h0005);
      reg_read(v);
      chk($sformatf("R6 R12 cleared by read, event %0d", k), v, 16'h0001);
      to_listen();
   endtask

   task automatic t_mismatch();
      logic [15:0] v;
      pulse(3);
      pulse(5);
      chk("R5 no power on mismatch", {15'd0, pwr_req}, 16'd0);
      reg_read(v);
      chk("R5 standard bit on mismatch", v, 16'h0005);
      to_listen();
   endtask

   task automatic t_std_clears();
      logic [15:0] v;
      pulse(0);
      link_up = 1'b1;
      step();
      chk("R6 passive on link", {15'd0, adv_np}, 16'd0);
      reg_read(v);
      chk("R6 standard cleared by link", v, 16'h0001);
      link_up = 1'b0;
      step();
      chk("R2 resumes after link drop", {15'd0, adv_np}, 16'd1);
      pulse(0);
      an_enable = 1'b0;
      step();
      chk("R3 adv_np off with an disabled", {15'd0, adv_np}, 16'd0);
      reg_read(v);
      chk("R6 standard cleared by an disable", v, 16'h0001);
      an_enable = 1'b1;
      step();
      chk("R3 adv_np back with an enabled", {15'd0, adv_np}, 16'd1);
   endtask

   task automatic t_link_first();
      logic [15:0] v;
      reg_write(16'h0000);
      step();
      link_up = 1'b1;
      reg_write(16'h0001);
      for (int i = 0; i < 4; i++) step();
      chk("R2 passive while link up", {15'd0, adv_np}, 16'd0);
      reg_read(v);
      chk("R1 enable held during link", v, 16'h0001);
      link_up = 1'b0;
      step();
      chk("R2 starts after link drop", {15'd0, adv_np}, 16'd1);
   endtask

   task automatic t_interrupt();
      logic [15:0] v;
      pulse(3);
      link_up = 1'b1;
      step();
      chk("R8 np_send drops on link", {15'd0, np_send}, 16'd0);
      chk("R8 no power on interrupt", {15'd0, pwr_req}, 16'd0);
      reg_read(v);
      chk("R8 register on interrupt", v, 16'h0001);
      link_up = 1'b0;
      step();
   endtask

   task automatic t_timeout();
      logic [15:0] v;
      pulse(3);
      pulse(6);
      chk("R9 back to listening", {np_send, adv_np}, 16'b01);
      reg_read(v);
      chk("R9 timeout bit", v, 16'h0009);
      reg_read(v);
      chk("R10 timeout cleared by read", v, 16'h0001);
      pulse(0);
      reg_read(v);
      chk("R9 detects after restart", v, 16'h0005);
      to_listen();
      pulse(6);
      pulse(0);
      reg_write(16'h0000);
      step();
      reg_read(v);
      chk("R10 cleared by discovery disable", v, 16'h0000);
      chk("R3 passive when disabled", {15'd0, adv_np}, 16'd0);
      reg_write(16'h0001);
      step();
   endtask

   task automatic t_set_wins();
      logic [15:0] v;
      pulse(0);
      mgmt_rd = 1'b1;
      nlp_seen = 1'b1;
      #1 v = mgmt_rdata;
      chk("R12 read shows set bit", v, 16'h0005);
      step();
      mgmt_rd = 1'b0;
      nlp_seen = 1'b0;
      reg_read(v);
      chk("R11 standard set beats read", v, 16'h0005);
      mgmt_rd = 1'b1;
      lfi_expired = 1'b1;
      #1 v = mgmt_rdata;
      chk("R12 read before timeout set", v, 16'h0001);
      step();
      mgmt_rd = 1'b0;
      lfi_expired = 1'b0;
      reg_read(v);
      chk("R11 timeout set beats read", v, 16'h0009);
      to_listen();
   endtask

   task automatic t_write_ignored();
      logic [15:0] v;
      pulse(0);
      reg_write(16'h0001);
      reg_read(v);
      chk("R7 status survives write", v, 16'h0005);
      reg_write(16'hFFFF);
      reg_read(v);
      chk("R7 status bits not writable", v, 16'h0001);
      to_listen();
   endtask

   initial begin
      #(4 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_enable();
      t_found();
      t_evidence(0);
      t_evidence(1);
      t_evidence(2);
      t_mismatch();
      t_std_clears();
      t_link_first();
      t_interrupt();
      t_timeout();
      t_set_wins();
      t_write_ignored();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule